// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is a byte-wide control and status register that sits on the processor's data bus at one fixed address. It governs how the chip behaves in its two low-power states, stop and wait. Two status flags record that a stop or a wait instruction has run. The instruction decoder raises these flags through one-cycle strobes. Software can clear a flag but cannot set it. Only a power-on reset clears the flags, so after a hardware or software reset the boot code can still tell that the chip came out of a low-power state.

Four writable control bits set the low-power behaviour. One hands the external bus pins over to general-purpose port control while the chip is in stop or wait. One stops the system clock and the peripheral clocks during wait. The other two are plain mode exports: an address-bus output policy, and the clock source of an event-counting timer. The clock-stop and pin-handover outputs are registered and qualified by the chip's current wait and stop mode flags.

Top module: `lpm_ctrl_reg`

## Requirements
- R1: A power-on reset clears every bit of the register, so a read of address 0x63 returns 0x00. All gating outputs are 0 after it.
- R2: A stop strobe sets bit 0 and a wait strobe sets bit 1, on the clock edge where the strobe is high.
- R3: Writing 1 to bit 0 or bit 1 leaves that bit unchanged. Writing 0 clears it. So each status bit becomes old AND written value.
- R4: A hardware or software reset leaves bits 0 and 1 at their prior values and clears bits 2 to 5 to 0.
- R5: When a status strobe and a write of 0 to the same status bit occur in the same cycle, the bit ends at 1.
- R6: Bits 2 to 5 are written from the data bus and read back unchanged. Bits 6 and 7 always read 0. Reads of any address other than 0x63 return 0, and writes to any other address change nothing.
- R7: The system-clock stop and peripheral-clock stop outputs go to 1 on the edge after both bit 3 and the wait flag are 1. They return to 0 on the first edge after the wait flag falls.
- R8: The bus-to-port handover output is registered. It equals bit 2 AND (wait flag OR stop flag) as sampled on the previous edge.
- R9: The address-output select output follows bit 4 and the timer clock-source select output follows bit 5, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_por | input | 1 | Power-on reset, synchronous, active high |
| rst_hw | input | 1 | Hardware reset, synchronous, active high |
| rst_sw | input | 1 | Software reset, synchronous, active high |
| bus_addr | input | 8 | Processor byte address |
| bus_we | input | 1 | Write enable for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| stp_exec | input | 1 | One-cycle strobe: stop instruction executed |
| wit_exec | input | 1 | One-cycle strobe: wait instruction executed |
| wait_active | input | 1 | Chip is currently in wait mode |
| stop_active | input | 1 | Chip is currently in stop mode |
| sysclk_stop | output | 1 | Stop the system clock (registered) |
| periph_clk_stop | output | 1 | Stop the peripheral clocks (registered) |
| bus_to_port | output | 1 | Hand bus pins to port control (registered) |
| addr_out_sel | output | 1 | 1: address bus changes only on external accesses |
| tmr_clk_src | output | 1 | 1: timer counts internal clock divided by 32; 0: external pin edges |

## Verification
Every cycle, assertions check the following. Status flags never rise without a strobe. A strobe always leaves its flag set, even against a clearing write. Hardware and software resets keep the flags and zero the control bits. The registered gate outputs follow the mode flags one edge later. Only the bench's sweeps can show that the full readback pattern holds for all 256 write values, both with the flags clear and with them set. The same is true for address decoding over the whole address space and for every combination of control bits and mode flags at the gate outputs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned STAT_W  = 2;
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned CTRL_LSB = STAT_W;
  localparam int unsigned CTRL_MSB = STAT_W + CTRL_W - 1;

  // control field order, msb first: timer source, addr policy, wait clock stop, standby pins
  typedef struct packed {
    logic tsrc;
    logic aout;
    logic wclk;
    logic stby;
  } lpm_ctrl_t;

  typedef struct packed {
    logic wit;
    logic stp;
  } lpm_stat_t;

  function automatic logic [REG_W-1:0] lpm_pack(lpm_stat_t s, lpm_ctrl_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[STAT_W-1:0] = s;
    r[CTRL_MSB:CTRL_LSB] = c;
    return r;
  endfunction

  function automatic lpm_ctrl_t lpm_ctrl_of(logic [CTRL_W-1:0] f);
    return lpm_ctrl_t'(f);
  endfunction

  // a status bit after a software write: only zeros take effect
  function automatic logic [STAT_W-1:0] lpm_stat_after_wr(logic [STAT_W-1:0] old_v,
                                                           logic [STAT_W-1:0] wr_v);
    return old_v & wr_v;
  endfunction
endpackage

// File: rtl/lpm_status_bits.sv
module lpm_status_bits
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_hw,
  input  logic              rst_sw,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              wr_hit,
  input  logic [STAT_W-1:0] wr_bits,
  output logic [STAT_W-1:0] stat_q
);
  logic soft_hold;
  logic wr_take;
  logic [STAT_W-1:0] wr_next;

  assign soft_hold = rst_hw | rst_sw;
  assign wr_take   = wr_hit & ~soft_hold;
  assign wr_next   = lpm_stat_after_wr(stat_q, wr_bits);

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst_por)          stat_q[i] <= 1'b0;
      else if (set_vec[i])  stat_q[i] <= 1'b1;
      else if (wr_take)     stat_q[i] <= wr_next[i];
    end

    // R2 R5
    stat_set_chk: assert property (@(posedge clk) disable iff (rst_por)
      set_vec[i] |=> stat_q[i]);

    // R3
    no_sw_set_chk: assert property (@(posedge clk) disable iff (rst_por)
      (!stat_q[i] && !set_vec[i]) |=> !stat_q[i]);
  end

  // R4
  stat_keep_chk: assert property (@(posedge clk) disable iff (rst_por)
    (soft_hold && set_vec == '0) |=> $stable(stat_q));
endmodule

// File: rtl/lpm_ctrl_bits.sv
module lpm_ctrl_bits
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_any,
  input  logic              rst_soft,
  input  logic              rst_por,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wr_bits,
  output lpm_ctrl_t         ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst_any)      ctrl_q <= '0;
    else if (wr_hit)  ctrl_q <= lpm_ctrl_of(wr_bits);
  end

  // R4
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (rst_por)
    rst_soft |=> (ctrl_q == '0));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
    !wr_hit |=> $stable(ctrl_q));
endmodule

// File: rtl/lpm_gate_out.sv
module lpm_gate_out
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_any,
  input  lpm_ctrl_t ctrl,
  input  logic      wait_active,
  input  logic      stop_active,
  output logic      sysclk_stop_q,
  output logic      periph_stop_q,
  output logic      port_sel_q
);
  logic low_power;
  logic wait_gate;
  logic pin_handover;

  assign low_power    = wait_active | stop_active;
  assign wait_gate    = ctrl.wclk & wait_active;
  assign pin_handover = ctrl.stby & low_power;

  always_ff @(posedge clk) begin
    if (rst_any) begin
      sysclk_stop_q <= 1'b0;
      periph_stop_q <= 1'b0;
      port_sel_q    <= 1'b0;
    end else begin
      sysclk_stop_q <= wait_gate;
      periph_stop_q <= wait_gate;
      port_sel_q    <= pin_handover;
    end
  end

  // R7
  gate_exit_chk: assert property (@(posedge clk) disable iff (rst_any)
    !wait_active |=> (!sysclk_stop_q && !periph_stop_q));

  // R7
  gate_enter_chk: assert property (@(posedge clk) disable iff (rst_any)
    (wait_active && ctrl.wclk) |=> (sysclk_stop_q && periph_stop_q));

  // R8
  port_idle_chk: assert property (@(posedge clk) disable iff (rst_any)
    !low_power |=> !port_sel_q);
endmodule

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h63
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_hw,
  input  logic              rst_sw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              stp_exec,
  input  logic              wit_exec,
  input  logic              wait_active,
  input  logic              stop_active,
  output logic              sysclk_stop,
  output logic              periph_clk_stop,
  output logic              bus_to_port,
  output logic              addr_out_sel,
  output logic              tmr_clk_src
);
  logic addr_hit;
  logic wr_hit;
  logic rst_any;
  logic rst_soft;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_q;
  lpm_ctrl_t ctrl_q;
  logic unused_rsvd;

  assign addr_hit    = (bus_addr == REG_ADDR);
  assign wr_hit      = bus_we & addr_hit;
  assign rst_soft    = rst_hw | rst_sw;
  assign rst_any     = rst_por | rst_soft;
  assign set_vec     = {wit_exec, stp_exec};
  assign unused_rsvd = ^bus_wdata[REG_W-1:CTRL_MSB+1];

  lpm_status_bits u_stat (
    .clk     (clk),
    .rst_por (rst_por),
    .rst_hw  (rst_hw),
    .rst_sw  (rst_sw),
    .set_vec (set_vec),
    .wr_hit  (wr_hit),
    .wr_bits (bus_wdata[STAT_W-1:0]),
    .stat_q  (stat_q)
  );

  lpm_ctrl_bits u_ctrl (
    .clk      (clk),
    .rst_any  (rst_any),
    .rst_soft (rst_soft),
    .rst_por  (rst_por),
    .wr_hit   (wr_hit),
    .wr_bits  (bus_wdata[CTRL_MSB:CTRL_LSB]),
    .ctrl_q   (ctrl_q)
  );

  lpm_gate_out u_gate (
    .clk           (clk),
    .rst_any       (rst_any),
    .ctrl          (ctrl_q),
    .wait_active   (wait_active),
    .stop_active   (stop_active),
    .sysclk_stop_q (sysclk_stop),
    .periph_stop_q (periph_clk_stop),
    .port_sel_q    (bus_to_port)
  );

  assign bus_rdata    = addr_hit ? lpm_pack(lpm_stat_t'(stat_q), ctrl_q) : '0;
  assign addr_out_sel = ctrl_q.aout;
  assign tmr_clk_src  = ctrl_q.tsrc;

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst_por)
    bus_rdata[REG_W-1:CTRL_MSB+1] == '0);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst_por)
    !addr_hit |-> (bus_rdata == '0));

  // R1
  por_clear_chk: assert property (@(posedge clk)
    $past(rst_por) |-> (stat_q == '0 && ctrl_q == '0 && !sysclk_stop && !bus_to_port));
endmodule

// File: tb/lpm_ctrl_reg_tb.sv
module lpm_ctrl_reg_tb;
  logic clk = 1'b0;
  logic rst_por = 1'b1, rst_hw = 1'b0, rst_sw = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic stp_exec = 1'b0, wit_exec = 1'b0;
  logic wait_active = 1'b0, stop_active = 1'b0;
  logic sysclk_stop, periph_clk_stop, bus_to_port, addr_out_sel, tmr_clk_src;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  localparam logic [7:0] REG = 8'h63;

  lpm_ctrl_reg u_dut (
    .clk(clk), .rst_por(rst_por), .rst_hw(rst_hw), .rst_sw(rst_sw),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stp_exec(stp_exec), .wit_exec(wit_exec),
    .wait_active(wait_active), .stop_active(stop_active),
    .sysclk_stop(sysclk_stop), .periph_clk_stop(periph_clk_stop),
    .bus_to_port(bus_to_port), .addr_out_sel(addr_out_sel), .tmr_clk_src(tmr_clk_src)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic strobe(input logic s, input logic w);
    stp_exec = s; wit_exec = w;
    @(negedge clk);
    stp_exec = 1'b0; wit_exec = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_por = 1'b0;
    // R1 reset state
    rd("R1", REG, 8'h00);
    chk("R1", {5'b0, sysclk_stop, periph_clk_stop, bus_to_port}, 8'h00);

    // R2 stop and wait strobes
    strobe(1'b1, 1'b0);
    rd("R2", REG, 8'h01);
    strobe(1'b0, 1'b1);
    rd("R2", REG, 8'h03);

    // R3 write 1 keeps, write 0 clears
    wr(REG, 8'h03); rd("R3", REG, 8'h03);
    wr(REG, 8'h02); rd("R3", REG, 8'h02);
    wr(REG, 8'h00); rd("R3", REG, 8'h00);

    // R3 R6 sweep, flags clear: only bits 5..2 can appear
    for (int d = 0; d < 256; d++) begin
      wr(REG, d[7:0]);
      rd("R3_R6", REG, d[7:0] & 8'h3C);
    end

    // R3 R6 sweep, flags set before each write: flags become old AND data
    for (int d = 0; d < 256; d++) begin
      strobe(1'b1, 1'b1);
      wr(REG, d[7:0]);
      rd("R3_R6", REG, d[7:0] & 8'h3F);
    end

    // R5 set wins over a clearing write in the same cycle
    wr(REG, 8'h00);
    stp_exec = 1'b1; wr(REG, 8'h00); stp_exec = 1'b0;
    rd("R5", REG, 8'h01);
    wit_exec = 1'b1; wr(REG, 8'h00); wit_exec = 1'b0;
    rd("R5", REG, 8'h02);

    // R4 hardware and software resets
    strobe(1'b1, 1'b1);
    wr(REG, 8'h3F);
    rst_hw = 1'b1; @(negedge clk); rst_hw = 1'b0;
    rd("R4", REG, 8'h03);
    wr(REG, 8'h3D);
    rst_sw = 1'b1; @(negedge clk); rst_sw = 1'b0;
    rd("R4", REG, 8'h01);
    wr(REG, 8'h3F);
    rst_por = 1'b1; @(negedge clk); rst_por = 1'b0;
    rd("R1", REG, 8'h00);

    // R6 address decode over the whole space
    wr(REG, 8'h14);
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != REG) begin
        wr(a[7:0], 8'hFF);
        rd("R6", a[7:0], 8'h00);
      end
    end
    rd("R6", REG, 8'h14);

    // R9 mode exports
    wr(REG, 8'h10);
    chk("R9", {6'b0, tmr_clk_src, addr_out_sel}, 8'h01);
    wr(REG, 8'h20);
    chk("R9", {6'b0, tmr_clk_src, addr_out_sel}, 8'h02);

    // R7 R8 all control and mode combinations
    for (int c = 0; c < 4; c++) begin
      wr(REG, {4'b0, c[1:0], 2'b00});
      for (int m = 0; m < 4; m++) begin
        wait_active = m[0]; stop_active = m[1];
        @(negedge clk);
        chk("R7", {6'b0, sysclk_stop, periph_clk_stop}, {8{c[1] & m[0]}} & 8'h03);
        chk("R8", {7'b0, bus_to_port}, {7'b0, c[0] & (m[0] | m[1])});
        wait_active = 1'b0; stop_active = 1'b0;
        #0.5;
        chk("R7", {7'b0, sysclk_stop}, {7'b0, c[1] & m[0]});
        @(negedge clk);
        chk("R7", {6'b0, sysclk_stop, periph_clk_stop}, 8'h00);
        chk("R8", {7'b0, bus_to_port}, 8'h00);
      end
    end

    // R7 reset exits the gate
    wr(REG, 8'h08);
    wait_active = 1'b1; @(negedge clk);
    chk("R7", {7'b0, sysclk_stop}, 8'h01);
    rst_hw = 1'b1; @(negedge clk); rst_hw = 1'b0; wait_active = 1'b0;
    chk("R7", {7'b0, sysclk_stop}, 8'h00);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule